// File: doc/BRIEF.md
# Load/Store Lane Alignment and Extension Unit

This block sits between a 32-bit core and a memory that is one word wide. A request carries a base register value, a signed 16-bit displacement, an access size, a signed/unsigned flag and a load/store flag. The block forms the effective address. It checks that the address is aligned to the access size. It then steers data between the memory word and the core.

For a load, the unit takes the memory word that arrives with the request. It picks the addressed byte or halfword lane and extends the result to a full word, with sign or zero fill. For a store, it moves the low byte or low halfword of the source register onto the lanes that the address selects and produces the matching byte enables.

A misaligned request writes nothing. It raises a fault with a code that tells a load from a store, and it records the faulting address. All results are registered and appear one clock after the request. A parameter chooses little-endian or big-endian lane numbering.

Top module: `lsu_align`

## Requirements
- R1: The effective address is `req_base` plus `req_imm` sign-extended to 32 bits. It appears on `rsp_addr` one cycle after an accepted request (`req_valid`=1), including misaligned requests.
- R2: A signed byte load (`req_size`=2'b00, `req_unsigned`=0) returns the selected byte with bit 7 copied into bits 31:8.
- R3: An unsigned byte load (`req_size`=2'b00, `req_unsigned`=1) returns the selected byte with bits 31:8 cleared.
- R4: A halfword load (`req_size`=2'b01) returns the selected 16-bit lane. Bits 31:16 copy bit 15 when signed and are zero when unsigned.
- R5: A word load (`req_size`=2'b10, or the reserved code 2'b11, which acts as a word) returns the memory word unchanged. On every valid load, `mem_be` is 0 and `mem_wdata` is 0.
- R6: Lane k is bits 8k+7:8k of the memory word. With `BIG_ENDIAN`=0, a byte uses lane addr[1:0] and a halfword uses bits 16*addr[1]+15:16*addr[1]. With `BIG_ENDIAN`=1, a byte uses lane 3-addr[1:0] and a halfword uses lane pair 1-addr[1].
- R7: A byte store puts `req_wsrc[7:0]` on the selected lane and zero on the other lanes. `mem_be` is one-hot on that lane. `rsp_load_data` is 0.
- R8: A halfword store puts `req_wsrc[15:0]` on the selected lane pair, and `mem_be` is 4'b0011 or 4'b1100.
- R9: A word store drives `req_wsrc` unchanged, with `mem_be`=4'b1111.
- R10: A halfword at an odd address, or a word at an address that is not a multiple of 4, raises `fault_valid`. `fault_code` is 4 for a load and 5 for a store. Byte accesses never fault. `fault_code` is 0 whenever `fault_valid` is 0.
- R11: A faulting request drives `mem_be`=0, `mem_wdata`=0 and `rsp_load_data`=0, and loads the effective address into `fault_addr`. `fault_addr` keeps its value until the next fault.
- R12: A cycle with `req_valid`=0 gives `rsp_valid`=0, `mem_be`=0 and `fault_valid`=0 on the next cycle. `rsp_load_data`, `mem_wdata` and `rsp_addr` hold their values.
- R13: While `rst` is high, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_unsigned | input | 1 | Zero-extend loads when 1 |
| req_base | input | 32 | Base register value |
| req_imm | input | 16 | Signed displacement |
| req_wsrc | input | 32 | Store source register |
| mem_rdata | input | 32 | Memory word for a load request |
| rsp_valid | output | 1 | Result of last cycle's request |
| rsp_load_data | output | 32 | Extended load result |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_be | output | 4 | Byte enables, bit k = lane k |
| rsp_addr | output | 32 | Effective address |
| fault_valid | output | 1 | Alignment fault |
| fault_code | output | 5 | 4 load fault, 5 store fault |
| fault_addr | output | 32 | Address of most recent fault |

## Verification
Every output is due exactly one clock edge after the request that produced it. The bench drives a request on a falling edge, predicts its outcome at once, and compares the prediction at the next falling edge, one rising edge later. The outputs that hold (load data, store data, effective address, fault address) are predicted from the bench's own held copies. An idle cycle or a clean access after a fault therefore shows whether the value stayed put. Two instances, one per lane numbering, get the same stimulus every cycle.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } lsu_size_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  input  logic [1:0]        size,
  output logic [DATA_W-1:0] eff,
  output logic              misaligned
);
  import lsu_pkg::*;
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  assign eff = base + {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};

  always_comb begin
    unique case (lsu_size_e'(size))
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = eff[0];
      default: misaligned = |eff[OFF_W-1:0];
    endcase
  end
endmodule

// File: rtl/lsu_load_steer.sv
module lsu_load_steer #(
  parameter int DATA_W     = 32,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic [DATA_W-1:0]             rdata,
  input  logic [$clog2(DATA_W/8)-1:0]   off,
  input  logic [1:0]                    size,
  input  logic                          uns,
  output logic [DATA_W-1:0]             data
);
  import lsu_pkg::*;
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);
  localparam int HIDX_W = (OFF_W > 1) ? OFF_W - 1 : 1;

  logic [OFF_W-1:0]  blane;
  logic [HIDX_W-1:0] hidx;
  logic [7:0]        bsel;
  logic [15:0]       hsel;

  generate
    if (BIG_ENDIAN) begin : g_be
      assign blane = ~off;
      assign hidx  = ~off[OFF_W-1:1];
    end else begin : g_le
      assign blane = off;
      assign hidx  = off[OFF_W-1:1];
    end
  endgenerate

  assign bsel = rdata[{blane, 3'b000} +: 8];
  assign hsel = rdata[{hidx, 4'b0000} +: 16];

  always_comb begin
    unique case (lsu_size_e'(size))
      SZ_BYTE: data = {{(DATA_W-8){bsel[7] & ~uns}}, bsel};
      SZ_HALF: data = {{(DATA_W-16){hsel[15] & ~uns}}, hsel};
      default: data = rdata;
    endcase
  end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer #(
  parameter int DATA_W     = 32,
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic [DATA_W-1:0]             wsrc,
  input  logic [$clog2(DATA_W/8)-1:0]   off,
  input  logic [1:0]                    size,
  output logic [DATA_W-1:0]             wdata,
  output logic [DATA_W/8-1:0]           be
);
  import lsu_pkg::*;
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);
  localparam int HIDX_W = (OFF_W > 1) ? OFF_W - 1 : 1;

  logic [OFF_W-1:0]  blane;
  logic [HIDX_W-1:0] hidx;

  generate
    if (BIG_ENDIAN) begin : g_be
      assign blane = ~off;
      assign hidx  = ~off[OFF_W-1:1];
    end else begin : g_le
      assign blane = off;
      assign hidx  = off[OFF_W-1:1];
    end
  endgenerate

  always_comb begin
    wdata = '0;
    be    = '0;
    for (int l = 0; l < LANES; l++) begin
      unique case (lsu_size_e'(size))
        SZ_BYTE: if (OFF_W'(l) == blane) begin
          wdata[l*8 +: 8] = wsrc[7:0];
          be[l]           = 1'b1;
        end
        SZ_HALF: if (HIDX_W'(l >> 1) == hidx) begin
          wdata[l*8 +: 8] = wsrc[(l%2)*8 +: 8];
          be[l]           = 1'b1;
        end
        default: begin
          wdata[l*8 +: 8] = wsrc[l*8 +: 8];
          be[l]           = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/lsu_align.sv
module lsu_align #(
  parameter int DATA_W           = 32,
  parameter int IMM_W            = 16,
  parameter bit BIG_ENDIAN       = 1'b0,
  parameter int CODE_W           = 5,
  parameter int LOAD_FAULT_CODE  = 4,
  parameter int STORE_FAULT_CODE = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_store,
  input  logic [1:0]           req_size,
  input  logic                 req_unsigned,
  input  logic [DATA_W-1:0]    req_base,
  input  logic [IMM_W-1:0]     req_imm,
  input  logic [DATA_W-1:0]    req_wsrc,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_load_data,
  output logic [DATA_W-1:0]    mem_wdata,
  output logic [DATA_W/8-1:0]  mem_be,
  output logic [DATA_W-1:0]    rsp_addr,
  output logic                 fault_valid,
  output logic [CODE_W-1:0]    fault_code,
  output logic [DATA_W-1:0]    fault_addr
);
  import lsu_pkg::*;
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  logic [DATA_W-1:0] eff;
  logic              misal;
  logic [DATA_W-1:0] ld_next;
  logic [DATA_W-1:0] st_data;
  logic [LANES-1:0]  st_be;

  lsu_agen #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_agen (
    .base(req_base), .imm(req_imm), .size(req_size),
    .eff(eff), .misaligned(misal)
  );

  lsu_load_steer #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_ld (
    .rdata(mem_rdata), .off(eff[OFF_W-1:0]), .size(req_size),
    .uns(req_unsigned), .data(ld_next)
  );

  lsu_store_steer #(.DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)) u_st (
    .wsrc(req_wsrc), .off(eff[OFF_W-1:0]), .size(req_size),
    .wdata(st_data), .be(st_be)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_load_data <= '0;
      mem_wdata     <= '0;
      mem_be        <= '0;
      rsp_addr      <= '0;
      fault_valid   <= 1'b0;
      fault_code    <= '0;
      fault_addr    <= '0;
    end else begin
      rsp_valid   <= req_valid;
      fault_valid <= 1'b0;
      fault_code  <= '0;
      mem_be      <= '0;
      if (req_valid) begin
        rsp_addr <= eff;
        if (misal) begin
          fault_valid   <= 1'b1;
          fault_code    <= req_store ? CODE_W'(STORE_FAULT_CODE)
                                     : CODE_W'(LOAD_FAULT_CODE);
          fault_addr    <= eff;
          rsp_load_data <= '0;
          mem_wdata     <= '0;
        end else if (req_store) begin
          rsp_load_data <= '0;
          mem_wdata     <= st_data;
          mem_be        <= st_be;
        end else begin
          rsp_load_data <= ld_next;
          mem_wdata     <= '0;
        end
      end
    end
  end

  assert_fault_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> (mem_be == '0 && rsp_load_data == '0 && mem_wdata == '0));

  assert_fault_addr_R11: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> fault_addr == rsp_addr);

  assert_fault_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !fault_valid |-> $stable(fault_addr));

  assert_fault_code_R10: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> fault_code == ($past(req_store) ? CODE_W'(STORE_FAULT_CODE)
                                                    : CODE_W'(LOAD_FAULT_CODE)));

  assert_byte_never_faults_R10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_size) == SZ_BYTE) |-> !fault_valid);

  assert_be_shape_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(mem_be) == 0 || $countones(mem_be) == 1 ||
    $countones(mem_be) == 2 || $countones(mem_be) == LANES);

  assert_load_no_be_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !$past(req_store)) |-> mem_be == '0);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (mem_be == '0 && !fault_valid && fault_code == '0));
endmodule

// File: tb/lsu_align_tb.sv
module lsu_align_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst;
  logic        req_valid, req_store, req_unsigned;
  logic [1:0]  req_size;
  logic [31:0] req_base, req_wsrc, mem_rdata;
  logic [15:0] req_imm;

  logic        o_v[2], o_fv[2];
  logic [31:0] o_ld[2], o_wd[2], o_ea[2], o_fa[2];
  logic [3:0]  o_be[2];
  logic [4:0]  o_fc[2];

  logic        e_v[2], e_fv[2];
  logic [31:0] e_ld[2], e_wd[2], e_ea[2], e_fa[2];
  logic [3:0]  e_be[2];
  logic [4:0]  e_fc[2];
  string       e_tag[2];
  string       e_atag;

  int n_chk = 0;
  int n_bad = 0;

  lsu_align #(.BIG_ENDIAN(1'b0)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
    .req_imm(req_imm), .req_wsrc(req_wsrc), .mem_rdata(mem_rdata),
    .rsp_valid(o_v[0]), .rsp_load_data(o_ld[0]), .mem_wdata(o_wd[0]),
    .mem_be(o_be[0]), .rsp_addr(o_ea[0]), .fault_valid(o_fv[0]),
    .fault_code(o_fc[0]), .fault_addr(o_fa[0]));

  lsu_align #(.BIG_ENDIAN(1'b1)) u_dut_be (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
    .req_imm(req_imm), .req_wsrc(req_wsrc), .mem_rdata(mem_rdata),
    .rsp_valid(o_v[1]), .rsp_load_data(o_ld[1]), .mem_wdata(o_wd[1]),
    .mem_be(o_be[1]), .rsp_addr(o_ea[1]), .fault_valid(o_fv[1]),
    .fault_code(o_fc[1]), .fault_addr(o_fa[1]));

  task automatic cmp(string tag, string fld, int inst, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s inst%0d: actual %h expected %h", tag, fld, inst, act, exp);
    end
  endtask

  task automatic check_all();
    for (int e = 0; e < 2; e++) begin
      cmp(e_tag[e], "rsp_valid", e, 32'(o_v[e]), 32'(e_v[e]));
      cmp(e_tag[e], "load_data", e, o_ld[e], e_ld[e]);
      cmp(e_tag[e], "wdata", e, o_wd[e], e_wd[e]);
      cmp(e_tag[e], "be", e, 32'(o_be[e]), 32'(e_be[e]));
      cmp(e_atag, "rsp_addr", e, o_ea[e], e_ea[e]);
      cmp(e_tag[e], "fault_valid", e, 32'(o_fv[e]), 32'(e_fv[e]));
      cmp(e_tag[e], "fault_code", e, 32'(o_fc[e]), 32'(e_fc[e]));
      cmp(e_tag[e], "fault_addr", e, o_fa[e], e_fa[e]);
    end
  endtask

  // Behavioural prediction of one request for both lane orders.
  task automatic predict();
    logic [31:0] ea;
    int          nb, lane, hi;
    logic [31:0] v;
    e_atag = req_valid ? "R1" : "R12";
    for (int e = 0; e < 2; e++) begin
      e_v[e] = req_valid;
      e_be[e] = 4'h0;
      e_fv[e] = 1'b0;
      e_fc[e] = 5'd0;
      if (!req_valid) begin
        e_tag[e] = "R12";
      end else begin
        ea = req_base + {{16{req_imm[15]}}, req_imm};
        e_ea[e] = ea;
        nb = (req_size == 2'b00) ? 1 : (req_size == 2'b01) ? 2 : 4;
        lane = (e == 1) ? 3 - int'(ea % 4) : int'(ea % 4);
        hi = (e == 1) ? 1 - int'((ea / 2) % 2) : int'((ea / 2) % 2);
        if ((ea % nb) != 0) begin
          e_tag[e] = "R10";
          e_fv[e] = 1'b1;
          e_fc[e] = req_store ? 5'd5 : 5'd4;
          e_fa[e] = ea;
          e_ld[e] = 0;
          e_wd[e] = 0;
        end else if (req_store) begin
          e_ld[e] = 0;
          if (nb == 1) begin
            e_tag[e] = (e == 1) ? "R6" : "R7";
            e_wd[e] = (req_wsrc & 32'hff) << (8 * lane);
            e_be[e] = 4'(1 << lane);
          end else if (nb == 2) begin
            e_tag[e] = (e == 1) ? "R6" : "R8";
            e_wd[e] = (req_wsrc & 32'hffff) << (16 * hi);
            e_be[e] = 4'(3 << (2 * hi));
          end else begin
            e_tag[e] = "R9";
            e_wd[e] = req_wsrc;
            e_be[e] = 4'hf;
          end
        end else begin
          e_wd[e] = 0;
          if (nb == 1) begin
            e_tag[e] = (e == 1) ? "R6" : (req_unsigned ? "R3" : "R2");
            v = (mem_rdata >> (8 * lane)) & 32'hff;
            if (!req_unsigned && v[7]) v = v | 32'hffffff00;
          end else if (nb == 2) begin
            e_tag[e] = (e == 1) ? "R6" : "R4";
            v = (mem_rdata >> (16 * hi)) & 32'hffff;
            if (!req_unsigned && v[15]) v = v | 32'hffff0000;
          end else begin
            e_tag[e] = "R5";
            v = mem_rdata;
          end
          e_ld[e] = v;
        end
      end
    end
  endtask

  task automatic step(input logic v, input logic st, input logic [1:0] sz, input logic u,
                      input logic [31:0] b, input logic [15:0] im,
                      input logic [31:0] ws, input logic [31:0] rd);
    @(negedge clk);
    check_all();
    req_valid = v; req_store = st; req_size = sz; req_unsigned = u;
    req_base = b; req_imm = im; req_wsrc = ws; mem_rdata = rd;
    predict();
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    req_valid = 0; req_store = 0; req_size = 0; req_unsigned = 0;
    req_base = 0; req_imm = 0; req_wsrc = 0; mem_rdata = 0;
    for (int e = 0; e < 2; e++) begin
      e_v[e] = 0; e_fv[e] = 0; e_ld[e] = 0; e_wd[e] = 0; e_ea[e] = 0;
      e_fa[e] = 0; e_be[e] = 0; e_fc[e] = 0; e_tag[e] = "R13";
    end
    e_atag = "R13";
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all();          // R13: reset state
    rst = 1'b0;
    predict();            // idle request after reset
    // R2 R3 R6: every byte lane, signed and unsigned
    for (int k = 0; k < 4; k++) begin
      step(1, 0, 2'b00, 0, 32'h1000, 16'(k), 32'h0, 32'h80F17F02);
      step(1, 0, 2'b00, 1, 32'h1000, 16'(k), 32'h0, 32'h80F17F02);
    end
    // R4: halfwords, both signs
    step(1, 0, 2'b01, 0, 32'h2000, 16'h0002, 0, 32'h8001_7FFE);
    step(1, 0, 2'b01, 1, 32'h2000, 16'h0002, 0, 32'h8001_7FFE);
    step(1, 0, 2'b01, 0, 32'h2000, 16'h0000, 0, 32'h8001_7FFE);
    // R5 word, reserved size
    step(1, 0, 2'b10, 0, 32'h3000, 16'h0004, 0, 32'hDEAD_BEEF);
    step(1, 0, 2'b11, 1, 32'h3000, 16'h0004, 0, 32'hCAFE_F00D);
    // R1 negative displacement
    step(1, 0, 2'b10, 0, 32'h0000_0010, 16'hFFF0, 0, 32'h1234_5678);
    // R7 R8 R9 stores
    for (int k = 0; k < 4; k++) step(1, 1, 2'b00, 0, 32'h400, 16'(k), 32'hAABBCCDD, 0);
    step(1, 1, 2'b01, 0, 32'h400, 16'h0000, 32'hAABBCCDD, 0);
    step(1, 1, 2'b01, 0, 32'h400, 16'h0002, 32'hAABBCCDD, 0);
    step(1, 1, 2'b10, 0, 32'h400, 16'h0000, 32'hAABBCCDD, 0);
    // R10 R11 faults then hold
    step(1, 0, 2'b01, 0, 32'h501, 16'h0000, 0, 32'hFFFFFFFF);
    step(0, 0, 2'b00, 0, 0, 0, 0, 0);
    step(1, 1, 2'b10, 0, 32'h600, 16'h0002, 32'h1, 0);
    step(1, 0, 2'b00, 0, 32'h700, 16'h0003, 0, 32'h11223344);
    step(1, 1, 2'b10, 0, 32'h800, 16'h0001, 32'h5, 0);
    step(0, 1, 2'b10, 0, 32'h900, 16'h0001, 32'h5, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      step(1'($urandom_range(0, 3) != 0), 1'($urandom), 2'($urandom), 1'($urandom),
           $urandom, 16'($urandom), $urandom, $urandom);
    end
    step(0, 0, 2'b00, 0, 0, 0, 0, 0);
    @(negedge clk);
    check_all();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule